// File: doc/BRIEF.md
# Single-Bus Multicycle Processor Core

This block is a compact 32-bit processor. Every register, the register file, the ALU result, the sign-extended immediate and the word memory share one internal transfer bus. In each cycle at most one source is enabled onto the bus, and any number of destinations capture it. A hardwired state machine steps through fetch and per-opcode execute microsteps. The program counter is incremented by routing it through operand register A and the ALU's increment function, so the increment also crosses the bus. Seven operations are supported: add, nand, add-immediate, load word, store word, branch-if-equal and halt.

A test harness holds the core in reset and preloads the program through a backdoor memory write port. It then releases reset and waits for the halted output. Register and memory contents are read back through two combinational backdoor read ports.

State machine. The states and their bus actions are:
- `S_F_MAR`: PC onto the bus, MAR loads.
- `S_F_IR`: memory onto the bus, IR loads.
- `S_F_A`: PC onto the bus, A loads.
- `S_F_PC`: ALU computes A+1, PC loads.
- `S_OPA`: register RA into A.
- `S_OPB_REG`: register RB into B.
- `S_OPB_IMM`: the immediate into B.
- `S_WB`: ALU result written to a register.
- `S_ADDR`: ALU sum into MAR.
- `S_LOAD`: memory written to register RB.
- `S_STORE`: register RB written to memory.
- `S_CMP`: ALU computes A-B; the zero flag picks the next state.
- `S_BR_A`: PC into A.
- `S_BR_B`: the immediate into B.
- `S_BR_PC`: ALU sum into PC.
- `S_HALT`: terminal state; nothing drives the bus.

Transitions out of `S_F_PC`:
- add, nand, addi, lw, sw and beq go to `S_OPA`.
- halt goes to `S_HALT`.
- Any other opcode goes back to `S_F_MAR`.

Transitions after `S_OPA`:
- `S_OPA` goes to `S_OPB_REG` for add, nand and beq, and to `S_OPB_IMM` otherwise.
- `S_OPB_REG` goes to `S_CMP` for beq and to `S_WB` otherwise.
- `S_OPB_IMM` goes to `S_WB` for addi and to `S_ADDR` otherwise.
- `S_ADDR` goes to `S_LOAD` for lw and to `S_STORE` for sw.
- `S_CMP` goes to `S_BR_A` when the bus is zero and to `S_F_MAR` otherwise.
- `S_BR_A` goes to `S_BR_B`, then `S_BR_PC`, then `S_F_MAR`.
- `S_WB`, `S_LOAD` and `S_STORE` go to `S_F_MAR`.

Top module: `sbus_core`

## Requirements
- R1: While `rst_n` is low, `halted` is 0, all registers read 0 and the PC is 0. Execution starts by fetching word 0 in the first cycle after release.
- R2: Instruction word fields:
  - The opcode is in bits 31..28, the first register RA in 27..24 and the second register RB in 23..20.
  - Register-register forms put the destination RD in bits 3..0.
  - Immediate forms put a 20-bit two's-complement value in bits 19..0, which is sign-extended to 32 bits.
- R3: Opcode 0000 writes RA+RB to RD. Opcode 0001 writes ~(RA & RB) to RD.
- R4: Opcode 0010 writes RA + sext(imm) to RB.
- R5: Opcode 0011 loads RB from memory word (RA + sext(imm)), using the low 10 address bits.
- R6: Opcode 0100 stores RB to memory word (RA + sext(imm)).
- R7: Opcode 0101 compares RA with RB by subtraction. If they are equal, the next PC is (address of the branch + 1 + sext(imm)). Otherwise execution continues at the next word.
- R8: Register 0 always reads 0, and writes to it are discarded.
- R9: Opcode 0111 raises `halted`. `halted` stays high, and no register or memory changes afterwards, until reset.
- R10: Opcode 0110 and opcodes 1000 to 1111 change no register or memory, and execution continues at the next word.
- R11: Until halt, every cycle has exactly one bus source enabled.
- R12: Each instruction takes a fixed number of cycles:
  - add, nand and addi take 7.
  - lw and sw take 8.
  - beq takes 7 when not taken and 10 when taken.
  - An unused opcode takes 4.
  - halt reaches `halted` after its 4 fetch cycles.
- R13: The fetch cycle that loads the PC leaves it exactly one greater than before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bd_we | input | 1 | Backdoor memory write enable; takes priority over a store |
| bd_addr | input | 10 | Backdoor memory word address |
| bd_wdata | input | 32 | Backdoor memory write data |
| bd_reg_idx | input | 4 | Backdoor register index to read |
| bd_reg_data | output | 32 | Contents of register `bd_reg_idx` |
| bd_mem_data | output | 32 | Contents of memory word `bd_addr` |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The taken-branch path is the hardest behaviour to reach from the ports. It needs two registers to hold equal values that were themselves produced through the bus. The branch must also skip words whose execution would be visible afterwards. The bench sweeps every pair from a set of boundary immediates: zero, one, minus one, both 20-bit extremes and an ordinary value. Equal pairs take the first branch and unequal pairs fall through it. An unconditional branch on register 0 then skips a marker write. The total cycle count to halt is compared against the sum of the per-instruction costs, which exposes any extra or missing microstep.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    localparam int DW      = 32;
    localparam int RIDX_W  = 4;
    localparam int IMM_W   = 20;
    localparam int OP_W    = 4;
    localparam int OP_LSB  = DW - OP_W;
    localparam int RA_LSB  = OP_LSB - RIDX_W;
    localparam int RB_LSB  = RA_LSB - RIDX_W;
    localparam int NREGS   = 1 << RIDX_W;

    typedef enum logic [3:0] {
        OP_ADD  = 4'b0000,
        OP_NAND = 4'b0001,
        OP_ADDI = 4'b0010,
        OP_LW   = 4'b0011,
        OP_SW   = 4'b0100,
        OP_BEQ  = 4'b0101,
        OP_JALR = 4'b0110,
        OP_HALT = 4'b0111
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_NAND = 2'b01,
        ALU_SUB  = 2'b10,
        ALU_INC  = 2'b11
    } alu_fn_e;

    typedef enum logic [1:0] {
        RSEL_RA = 2'd0,
        RSEL_RB = 2'd1,
        RSEL_RD = 2'd2
    } rsel_e;

    typedef enum logic [3:0] {
        S_F_MAR, S_F_IR, S_F_A, S_F_PC,
        S_OPA, S_OPB_REG, S_OPB_IMM,
        S_WB, S_ADDR, S_LOAD, S_STORE,
        S_CMP, S_BR_A, S_BR_B, S_BR_PC,
        S_HALT
    } state_e;

    typedef struct packed {
        logic    drv_pc;
        logic    drv_mem;
        logic    drv_alu;
        logic    drv_reg;
        logic    drv_imm;
        logic    ld_mar;
        logic    ld_ir;
        logic    ld_a;
        logic    ld_b;
        logic    ld_pc;
        logic    wr_reg;
        logic    wr_mem;
        alu_fn_e alu_fn;
        rsel_e   rsel;
    } ctrl_t;
endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
(
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  alu_fn_e       fn,
    output logic [DW-1:0] result
);
    always_comb begin
        unique case (fn)
            ALU_ADD:  result = op_a + op_b;
            ALU_NAND: result = ~(op_a & op_b);
            ALU_SUB:  result = op_a - op_b;
            ALU_INC:  result = op_a + {{(DW-1){1'b0}}, 1'b1};
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] idx,
    input  logic              we,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [RIDX_W-1:0] peek_idx,
    output logic [DW-1:0]     peek_data
);
    logic [DW-1:0] regs [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && idx != '0) begin
            regs[idx] <= wdata;
        end
    end

    assign rdata     = (idx == '0)      ? '0 : regs[idx];
    assign peek_data = (peek_idx == '0) ? '0 : regs[peek_idx];
endmodule

// File: rtl/sbus_mem.sv
module sbus_mem
    import sbus_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata     = words[raddr];
    assign peek_data = words[peek_addr];
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
    import sbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            bus_zero,
    output ctrl_t           ctl,
    output logic            halted
);
    state_e state, state_nx;
    opcode_e op;

    assign op = opcode_e'(opcode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_F_MAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_F_MAR: state_nx = S_F_IR;
            S_F_IR:  state_nx = S_F_A;
            S_F_A:   state_nx = S_F_PC;
            S_F_PC: begin
                unique case (op)
                    OP_ADD, OP_NAND, OP_ADDI,
                    OP_LW, OP_SW, OP_BEQ: state_nx = S_OPA;
                    OP_HALT:              state_nx = S_HALT;
                    default:              state_nx = S_F_MAR;
                endcase
            end
            S_OPA:     state_nx = (op == OP_ADD || op == OP_NAND || op == OP_BEQ)
                                  ? S_OPB_REG : S_OPB_IMM;
            S_OPB_REG: state_nx = (op == OP_BEQ) ? S_CMP : S_WB;
            S_OPB_IMM: state_nx = (op == OP_ADDI) ? S_WB : S_ADDR;
            S_ADDR:    state_nx = (op == OP_LW) ? S_LOAD : S_STORE;
            S_CMP:     state_nx = bus_zero ? S_BR_A : S_F_MAR;
            S_BR_A:    state_nx = S_BR_B;
            S_BR_B:    state_nx = S_BR_PC;
            S_WB, S_LOAD, S_STORE, S_BR_PC: state_nx = S_F_MAR;
            S_HALT:    state_nx = S_HALT;
            default:   state_nx = S_F_MAR;
        endcase
    end

    always_comb begin
        ctl        = '0;
        ctl.alu_fn = ALU_ADD;
        ctl.rsel   = RSEL_RA;
        unique case (state)
            S_F_MAR:   begin ctl.drv_pc  = 1'b1; ctl.ld_mar = 1'b1; end
            S_F_IR:    begin ctl.drv_mem = 1'b1; ctl.ld_ir  = 1'b1; end
            S_F_A:     begin ctl.drv_pc  = 1'b1; ctl.ld_a   = 1'b1; end
            S_F_PC:    begin ctl.drv_alu = 1'b1; ctl.ld_pc  = 1'b1; ctl.alu_fn = ALU_INC; end
            S_OPA:     begin ctl.drv_reg = 1'b1; ctl.ld_a   = 1'b1; ctl.rsel = RSEL_RA; end
            S_OPB_REG: begin ctl.drv_reg = 1'b1; ctl.ld_b   = 1'b1; ctl.rsel = RSEL_RB; end
            S_OPB_IMM: begin ctl.drv_imm = 1'b1; ctl.ld_b   = 1'b1; end
            S_WB: begin
                ctl.drv_alu = 1'b1;
                ctl.wr_reg  = 1'b1;
                ctl.alu_fn  = (op == OP_NAND) ? ALU_NAND : ALU_ADD;
                ctl.rsel    = (op == OP_ADDI) ? RSEL_RB : RSEL_RD;
            end
            S_ADDR:    begin ctl.drv_alu = 1'b1; ctl.ld_mar = 1'b1; ctl.alu_fn = ALU_ADD; end
            S_LOAD:    begin ctl.drv_mem = 1'b1; ctl.wr_reg = 1'b1; ctl.rsel = RSEL_RB; end
            S_STORE:   begin ctl.drv_reg = 1'b1; ctl.wr_mem = 1'b1; ctl.rsel = RSEL_RB; end
            S_CMP:     begin ctl.drv_alu = 1'b1; ctl.alu_fn = ALU_SUB; end
            S_BR_A:    begin ctl.drv_pc  = 1'b1; ctl.ld_a   = 1'b1; end
            S_BR_B:    begin ctl.drv_imm = 1'b1; ctl.ld_b   = 1'b1; end
            S_BR_PC:   begin ctl.drv_alu = 1'b1; ctl.ld_pc  = 1'b1; ctl.alu_fn = ALU_ADD; end
            S_HALT:    ;
            default:   ;
        endcase
    end

    assign halted = (state == S_HALT);

    // R12: fetch microsteps follow one another without gaps
    a_r12_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_F_MAR) |=> (state == S_F_IR));

    // R9: halt is terminal
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
endmodule

// File: rtl/sbus_core.sv
module sbus_core
    import sbus_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bd_we,
    input  logic [MEM_AW-1:0] bd_addr,
    input  logic [DW-1:0]     bd_wdata,
    input  logic [RIDX_W-1:0] bd_reg_idx,
    output logic [DW-1:0]     bd_reg_data,
    output logic [DW-1:0]     bd_mem_data,
    output logic              halted
);
    ctrl_t             ctl;
    logic [DW-1:0]     bus, pc, ir, a_q, b_q, alu_y, reg_q, mem_q, imm_x;
    logic [MEM_AW-1:0] mar;
    logic [RIDX_W-1:0] reg_idx;
    logic              bus_zero;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [DW-1:0]     mem_wdata;

    assign imm_x = {{(DW-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};

    always_comb begin
        unique case (ctl.rsel)
            RSEL_RA: reg_idx = ir[RA_LSB +: RIDX_W];
            RSEL_RB: reg_idx = ir[RB_LSB +: RIDX_W];
            RSEL_RD: reg_idx = ir[RIDX_W-1:0];
            default: reg_idx = '0;
        endcase
    end

    // shared bus: each source gated by its own drive enable
    assign bus = ({DW{ctl.drv_pc}}  & pc)
               | ({DW{ctl.drv_mem}} & mem_q)
               | ({DW{ctl.drv_alu}} & alu_y)
               | ({DW{ctl.drv_reg}} & reg_q)
               | ({DW{ctl.drv_imm}} & imm_x);
    assign bus_zero = (bus == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= '0;
            ir  <= '0;
            a_q <= '0;
            b_q <= '0;
            mar <= '0;
        end else begin
            if (ctl.ld_pc)  pc  <= bus;
            if (ctl.ld_ir)  ir  <= bus;
            if (ctl.ld_a)   a_q <= bus;
            if (ctl.ld_b)   b_q <= bus;
            if (ctl.ld_mar) mar <= bus[MEM_AW-1:0];
        end
    end

    assign mem_we    = bd_we | ctl.wr_mem;
    assign mem_waddr = bd_we ? bd_addr  : mar;
    assign mem_wdata = bd_we ? bd_wdata : bus;

    sbus_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (ir[OP_LSB +: OP_W]),
        .bus_zero (bus_zero),
        .ctl      (ctl),
        .halted   (halted)
    );

    sbus_alu u_alu (
        .op_a   (a_q),
        .op_b   (b_q),
        .fn     (ctl.alu_fn),
        .result (alu_y)
    );

    sbus_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (reg_idx),
        .we        (ctl.wr_reg),
        .wdata     (bus),
        .rdata     (reg_q),
        .peek_idx  (bd_reg_idx),
        .peek_data (bd_reg_data)
    );

    sbus_mem #(.AW(MEM_AW)) u_mem (
        .clk       (clk),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata),
        .raddr     (mar),
        .rdata     (mem_q),
        .peek_addr (bd_addr),
        .peek_data (bd_mem_data)
    );

    // R11: exactly one bus source per cycle until halt
    a_r11_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |-> $onehot({ctl.drv_pc, ctl.drv_mem, ctl.drv_alu, ctl.drv_reg, ctl.drv_imm}));

    // R13: the fetch increment advances the PC by one
    a_r13_pc_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld_pc && ctl.alu_fn == ALU_INC) |=> (pc == $past(pc) + 32'd1));

    // R6: memory is written by the core only while a store is decoded
    a_r6_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wr_mem |-> (ir[OP_LSB +: OP_W] == OP_SW));

    // R9: after halt the PC no longer moves
    a_r9_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));
endmodule

// File: tb/sbus_core_tb.sv
module sbus_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bd_we = 1'b0;
    logic [9:0]  bd_addr = '0;
    logic [31:0] bd_wdata = '0;
    logic [3:0]  bd_reg_idx = '0;
    logic [31:0] bd_reg_data, bd_mem_data;
    logic        halted;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    sbus_core dut_i (
        .clk (clk), .rst_n (rst_n), .bd_we (bd_we), .bd_addr (bd_addr),
        .bd_wdata (bd_wdata), .bd_reg_idx (bd_reg_idx),
        .bd_reg_data (bd_reg_data), .bd_mem_data (bd_mem_data), .halted (halted)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [19:0] v);
        return {{12{v[19]}}, v};
    endfunction

    function automatic logic [31:0] enc_i(input logic [3:0] op, input logic [3:0] ra,
                                          input logic [3:0] rb, input logic [19:0] imm);
        return {op, ra, rb, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [3:0] op, input logic [3:0] ra,
                                          input logic [3:0] rb, input logic [3:0] rd);
        return {op, ra, rb, 16'h0000, rd};
    endfunction

    function automatic logic [19:0] sweep_val(input int k);
        case (k)
            0: return 20'h00000;
            1: return 20'h00001;
            2: return 20'hFFFFF;
            3: return 20'h7FFFF;
            4: return 20'h80000;
            default: return 20'h03039;
        endcase
    endfunction

    task automatic poke(input int addr, input logic [31:0] w);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = addr[9:0]; bd_wdata = w;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic reg_rd(input int idx, output logic [31:0] v);
        @(negedge clk);
        bd_reg_idx = idx[3:0];
        #1 v = bd_reg_data;
    endtask

    task automatic mem_rd(input int addr, output logic [31:0] v);
        @(negedge clk);
        bd_addr = addr[9:0];
        #1 v = bd_mem_data;
    endtask

    task automatic run_case(input logic [19:0] ia, input logic [19:0] ib);
        logic [31:0] v, sa, sb, sum, r7_before;
        int n, exp_cyc;
        bit eq;
        @(negedge clk);
        rst_n = 1'b0;
        poke(0,  enc_i(4'b0010, 4'd0, 4'd1, ia));          // addi r1 = A
        poke(1,  enc_i(4'b0010, 4'd0, 4'd2, ib));          // addi r2 = B
        poke(2,  enc_r(4'b0000, 4'd1, 4'd2, 4'd3));        // add  r3
        poke(3,  enc_r(4'b0001, 4'd1, 4'd2, 4'd4));        // nand r4
        poke(4,  enc_i(4'b0100, 4'd0, 4'd3, 20'd100));     // sw r3 -> [100]
        poke(5,  enc_i(4'b0011, 4'd0, 4'd5, 20'd100));     // lw r5 <- [100]
        poke(6,  enc_i(4'b0010, 4'd1, 4'd0, 20'd7));       // addi r0 (discarded)
        poke(7,  enc_r(4'b0000, 4'd0, 4'd1, 4'd6));        // add r6 = r0 + r1
        poke(8,  enc_i(4'b0101, 4'd1, 4'd2, 20'd2));       // beq r1,r2,+2 -> 11
        poke(9,  enc_i(4'b0010, 4'd0, 4'd7, 20'd1));       // addi r7 = 1
        poke(10, enc_i(4'b0110, 4'd7, 4'd7, 20'd0));       // jalr: no-op
        poke(11, 32'hF777_FFFF);                           // unused opcode
        poke(12, enc_i(4'b0101, 4'd0, 4'd0, 20'd1));       // beq r0,r0,+1 -> 14
        poke(13, enc_i(4'b0010, 4'd0, 4'd9, 20'd99));      // skipped
        poke(14, enc_i(4'b0111, 4'd0, 4'd0, 20'd0));       // halt
        poke(100, 32'hDEAD_BEEF);
        // R1: reset state
        @(negedge clk);
        check("R1 halted in reset", {31'b0, halted}, 32'd0);
        reg_rd(3, v); check("R1 reg clear in reset", v, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < 400) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        sa = sx(ia); sb = sx(ib); sum = sa + sb;
        eq = (sa == sb);
        exp_cyc = eq ? 86 : 94;
        check("R12 R13 cycles to halt", n, exp_cyc);
        check("R9 halted raised", {31'b0, halted}, 32'd1);
        reg_rd(1, v); check("R2 R4 addi r1", v, sa);
        reg_rd(2, v); check("R4 addi r2", v, sb);
        reg_rd(3, v); check("R3 add", v, sum);
        reg_rd(4, v); check("R3 nand", v, ~(sa & sb));
        mem_rd(100, v); check("R6 store", v, sum);
        reg_rd(5, v); check("R5 load", v, sum);
        reg_rd(0, v); check("R8 r0 write discarded", v, 32'd0);
        reg_rd(6, v); check("R8 r0 reads zero", v, sa);
        reg_rd(7, v); check("R7 beq data-dependent", v, eq ? 32'd0 : 32'd1);
        reg_rd(9, v); check("R7 beq always-taken skip", v, 32'd0);
        reg_rd(8, v); check("R10 unused opcodes write nothing", v, 32'd0);
        mem_rd(7, v); check("R10 jalr leaves memory", v, enc_r(4'b0000, 4'd0, 4'd1, 4'd6));
        // R9 / R11: nothing moves after halt
        reg_rd(7, r7_before);
        repeat (20) @(negedge clk);
        check("R9 halted sticky", {31'b0, halted}, 32'd1);
        reg_rd(7, v); check("R9 R11 state frozen", v, r7_before);
        mem_rd(100, v); check("R9 memory frozen", v, sum);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                run_case(sweep_val(i), sweep_val(j));
            end
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule